// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block sits on the host I/O path. It provides the configuration address and data port pair that reaches a small configuration register file for bus 0, device 0, function 0. Each host I/O cycle carries a valid strobe, a direction, a DWORD-aligned port address, four byte enables and write data. The block either claims the cycle or forwards it unchanged on a pass-through I/O interface.

A full 32-bit write to port 0CF8h stores the configuration address. A later access to the data port at 0CFCh reaches the register file only when that stored address has its enable bit set and a zero bus/device/function field. The register file holds fixed identity values, writable command, status, latency and control bytes with reset defaults, and reserved space that reads as zero.

Read data is combinational in the same cycle as the request. Writes take effect at the clock edge that samples them.

Top module: `cfg_port_decoder`

## Requirements
- R1: A read or write to port 0CF8h with all four byte enables set (4'b1111) is claimed. A write stores io_wdata as the configuration address. A read returns the stored address.
- R2: An access to port 0CF8h with any other byte-enable pattern is not claimed. It goes to the pass-through interface and leaves the stored address unchanged.
- R3: An access to port 0CFCh is claimed only when stored address bit 31 is 1 and bits 23:8 are all zero. Otherwise it goes to the pass-through interface.
- R4: A claimed data-port access selects the DWORD at offset {addr[7:2],2'b00}. Stored address bits 30:24 and 1:0 have no effect on the selection.
- R5: The identity DWORDs are read-only. Offset 00h reads 32'h00011078 and offset 08h reads 32'h06000000, and writes to them change nothing.
- R6: After reset, offset 04h reads 32'h02800007, offset 0Ch reads 0, offset 40h reads 32'h80009600 and offset 44h reads 0.
- R7: A claimed write updates only the writable bytes whose byte enable is set. Lane n carries byte offset +n. All other bytes keep their value.
- R8: Reserved bytes ignore writes and read as zero. These are 0Ch, 0Eh–3Fh, 42h and 45h–FFh.
- R9: Reset clears the stored address to zero and reloads every writable byte with its default.
- R10: pt_valid is high exactly for valid cycles that are not claimed. On those cycles pt_write, pt_addr, pt_be and pt_wdata copy the host request, and for reads io_rdata returns pt_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_valid | input | 1 | Host I/O cycle present |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O port address (DWORD aligned, bits 1:0 forwarded only) |
| io_be | input | 4 | Byte enables, lane n = byte n |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Read data, valid in the request cycle |
| pt_valid | output | 1 | Unclaimed cycle forwarded |
| pt_write | output | 1 | Forwarded direction |
| pt_addr | output | 16 | Forwarded address |
| pt_be | output | 4 | Forwarded byte enables |
| pt_wdata | output | 32 | Forwarded write data |
| pt_rdata | input | 32 | Read data from the pass-through target |

## Verification
Claim decisions, pass-through signals and read data are all due in the same cycle as the request. The monitor therefore samples them one nanosecond before the rising edge that ends the request cycle. A write changes the stored address or a register at that edge, so the bench checks its effect with a read in the next request cycle. Reset release passes through two synchronizing flops, and the bench waits several cycles after deasserting reset before it starts any request.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam int IO_DW  = 32;
  localparam int IO_BEW = IO_DW / 8;

  localparam logic [15:0] ADDR_PORT = 16'h0CF8;
  localparam logic [15:0] DATA_PORT = 16'h0CFC;

  // writable configuration bytes
  localparam int NUM_WB = 9;

  function automatic logic [7:0] wb_offset(input int i);
    case (i)
      0:       wb_offset = 8'h04;
      1:       wb_offset = 8'h05;
      2:       wb_offset = 8'h06;
      3:       wb_offset = 8'h07;
      4:       wb_offset = 8'h0D;
      5:       wb_offset = 8'h40;
      6:       wb_offset = 8'h41;
      7:       wb_offset = 8'h43;
      default: wb_offset = 8'h44;
    endcase
  endfunction

  function automatic logic [7:0] wb_reset(input int i);
    case (i)
      0:       wb_reset = 8'h07;
      1:       wb_reset = 8'h00;
      2:       wb_reset = 8'h80;
      3:       wb_reset = 8'h02;
      4:       wb_reset = 8'h00;
      5:       wb_reset = 8'h00;
      6:       wb_reset = 8'h96;
      7:       wb_reset = 8'h80;
      default: wb_reset = 8'h00;
    endcase
  endfunction

  // fixed identity bytes; everything else not writable reads zero
  function automatic logic [7:0] ro_byte(input logic [7:0] off);
    case (off)
      8'h00:   ro_byte = 8'h78;
      8'h01:   ro_byte = 8'h10;
      8'h02:   ro_byte = 8'h01;
      8'h0B:   ro_byte = 8'h06;
      default: ro_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgdec_rst_sync.sv
module cfgdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cfgdec_port_decode.sv
module cfgdec_port_decode #(
  parameter int IO_AW = 16
) (
  input  logic               io_valid,
  input  logic [IO_AW-1:2]   io_port,
  input  logic [3:0]         io_be,
  input  logic               cfg_en,
  input  logic [15:0]        cfg_bdf,
  output logic               addr_hit,
  output logic               data_hit,
  output logic               claim
);

  import cfgdec_pkg::*;

  localparam logic [IO_AW-1:2] ADDR_SEL = IO_AW'(ADDR_PORT) >> 2;
  localparam logic [IO_AW-1:2] DATA_SEL = IO_AW'(DATA_PORT) >> 2;

  logic is_addr_port;
  logic is_data_port;
  logic target_ok;

  always_comb begin
    is_addr_port = (io_port == ADDR_SEL);
    is_data_port = (io_port == DATA_SEL);
    target_ok    = cfg_en && (cfg_bdf == 16'h0000);
    addr_hit     = io_valid && is_addr_port && (io_be == 4'hF);
    data_hit     = io_valid && is_data_port && target_ok;
    claim        = addr_hit || data_hit;
  end

endmodule

// File: rtl/cfgdec_addr_latch.sv
module cfgdec_addr_latch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cfg_addr
);

  logic [DW-1:0] addr_q;
  logic [DW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) addr_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign cfg_addr = addr_q;

endmodule

// File: rtl/cfgdec_regfile.sv
module cfgdec_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  index,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  import cfgdec_pkg::*;

  logic [7:0] wb_q [NUM_WB];

  for (genvar gi = 0; gi < NUM_WB; gi++) begin : g_wbyte
    localparam logic [7:0] OFF  = wb_offset(gi);
    localparam logic [7:0] RSTV = wb_reset(gi);
    localparam int         LANE = int'(OFF[1:0]);

    logic       hit;
    logic [7:0] byte_d;

    always_comb begin
      hit    = wr_en && (index == OFF[7:2]) && be[LANE];
      byte_d = hit ? wdata[8*LANE +: 8] : wb_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wb_q[gi] <= RSTV;
      else        wb_q[gi] <= byte_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < 4; b++) begin
      logic [7:0] off;
      logic [7:0] val;
      off = {index, 2'(b)};
      val = ro_byte(off);
      for (int i = 0; i < NUM_WB; i++) begin
        if (wb_offset(i) == off) val = wb_q[i];
      end
      rdata[8*b +: 8] = val;
    end
  end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder #(
  parameter int IO_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             pt_valid,
  output logic             pt_write,
  output logic [IO_AW-1:0] pt_addr,
  output logic [3:0]       pt_be,
  output logic [31:0]      pt_wdata,
  input  logic [31:0]      pt_rdata
);

  logic        rst_n_sync;
  logic [31:0] cfg_addr;
  logic        addr_hit;
  logic        data_hit;
  logic        claim;
  logic [31:0] rf_rdata;
  logic        addr_load;
  logic        rf_wr;

  cfgdec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cfgdec_port_decode #(.IO_AW(IO_AW)) u_dec (
    .io_valid (io_valid),
    .io_port  (io_addr[IO_AW-1:2]),
    .io_be    (io_be),
    .cfg_en   (cfg_addr[31]),
    .cfg_bdf  (cfg_addr[23:8]),
    .addr_hit (addr_hit),
    .data_hit (data_hit),
    .claim    (claim)
  );

  always_comb begin
    addr_load = addr_hit && io_write;
    rf_wr     = data_hit && io_write;
  end

  cfgdec_addr_latch #(.DW(32)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (addr_load),
    .load_val (io_wdata),
    .cfg_addr (cfg_addr)
  );

  cfgdec_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .wr_en (rf_wr),
    .index (cfg_addr[7:2]),
    .be    (io_be),
    .wdata (io_wdata),
    .rdata (rf_rdata)
  );

  always_comb begin
    if (addr_hit)      io_rdata = cfg_addr;
    else if (data_hit) io_rdata = rf_rdata;
    else               io_rdata = pt_rdata;
    pt_valid = io_valid && !claim;
    pt_write = io_write;
    pt_addr  = io_addr;
    pt_be    = io_be;
    pt_wdata = io_wdata;
  end

endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker #(
  parameter int IO_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_valid,
  input logic             io_write,
  input logic [IO_AW-1:2] io_port,
  input logic [3:0]       io_be,
  input logic [31:0]      io_wdata,
  input logic [31:0]      io_rdata,
  input logic             pt_valid,
  input logic [31:0]      cfg_addr
);

  localparam logic [IO_AW-1:2] APORT = IO_AW'(16'h0CF8) >> 2;
  localparam logic [IO_AW-1:2] DPORT = IO_AW'(16'h0CFC) >> 2;

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && io_port == APORT && io_be == 4'hF) |=> (cfg_addr == $past(io_wdata))); // R1

  AST_NARROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && io_port == APORT && io_be != 4'hF) |=> $stable(cfg_addr)); // R2

  AST_NARROW_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_port == APORT && io_be != 4'hF) |-> pt_valid); // R2

  AST_DATA_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_port == DPORT && !cfg_addr[31]) |-> pt_valid); // R3

  AST_VENDOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && io_port == DPORT && cfg_addr[31] &&
     cfg_addr[23:8] == 16'h0 && cfg_addr[7:2] == 6'h0) |-> (io_rdata == 32'h00011078)); // R5

  AST_PT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> !pt_valid); // R10

endmodule

bind cfg_port_decoder cfgdec_checker #(.IO_AW(IO_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .io_valid (io_valid),
  .io_write (io_write),
  .io_port  (io_addr[IO_AW-1:2]),
  .io_be    (io_be),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .pt_valid (pt_valid),
  .cfg_addr (cfg_addr)
);

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        io_valid;
  logic        io_write;
  logic [15:0] io_addr;
  logic [3:0]  io_be;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic        pt_valid;
  logic        pt_write;
  logic [15:0] pt_addr;
  logic [3:0]  pt_be;
  logic [31:0] pt_wdata;
  logic [31:0] pt_rdata;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        exp_pt;
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    string       req;
  } item_t;

  item_t exp_q[$];

  cfg_port_decoder uut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pt_valid(pt_valid), .pt_write(pt_write), .pt_addr(pt_addr), .pt_be(pt_be),
    .pt_wdata(pt_wdata), .pt_rdata(pt_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign pt_rdata = {16'hA5C3, pt_addr};

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: one request per cycle, expectation pushed alongside
  task automatic access(input logic wr, input logic [15:0] addr, input logic [3:0] be,
                        input logic [31:0] wdata, input logic exp_pt,
                        input logic [31:0] exp_rd, input string req);
    item_t it;
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = addr; io_be = be; io_wdata = wdata;
    it.exp_pt = exp_pt; it.wr = wr; it.addr = addr; it.be = be; it.wdata = wdata;
    it.exp_rd = exp_rd; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic cfg_wr(input logic [31:0] a, input string req);
    access(1'b1, 16'h0CF8, 4'hF, a, 1'b0, 32'h0, req);
  endtask

  task automatic cfg_rd(input logic [31:0] exp, input string req);
    access(1'b0, 16'h0CFC, 4'hF, 32'h0, 1'b0, exp, req);
  endtask

  task automatic data_wr(input logic [3:0] be, input logic [31:0] d, input string req);
    access(1'b1, 16'h0CFC, be, d, 1'b0, 32'h0, req);
  endtask

  // monitor: samples just before the closing edge of each request cycle
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check(it.req, "pt_valid", {31'h0, pt_valid}, {31'h0, it.exp_pt});
        if (it.exp_pt) begin
          check(it.req, "pt_write", {31'h0, pt_write}, {31'h0, it.wr});
          check(it.req, "pt_addr", {16'h0, pt_addr}, {16'h0, it.addr});
          check(it.req, "pt_be", {28'h0, pt_be}, {28'h0, it.be});
          if (it.wr) check(it.req, "pt_wdata", pt_wdata, it.wdata);
          else       check(it.req, "pt_rdata path", io_rdata, {16'hA5C3, it.addr});
        end else if (!it.wr) begin
          check(it.req, "io_rdata", io_rdata, it.exp_rd);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    io_valid = 0; io_write = 0; io_addr = 0; io_be = 0; io_wdata = 0;
    rst_n = 1'b0;
    do_reset();

    // R9: stored address cleared
    access(1'b0, 16'h0CF8, 4'hF, 0, 1'b0, 32'h0, "R9");
    // R3: enable clear -> forwarded
    access(1'b0, 16'h0CFC, 4'hF, 0, 1'b1, 0, "R3");
    // R1: store and read back
    cfg_wr(32'h8000_0000, "R1");
    access(1'b0, 16'h0CF8, 4'hF, 0, 1'b0, 32'h8000_0000, "R1");
    // R5: identity at 00h
    cfg_rd(32'h0001_1078, "R5");
    // R2: narrow write and narrow read are forwarded, address kept
    access(1'b1, 16'h0CF8, 4'h1, 32'h0000_0044, 1'b1, 0, "R2");
    access(1'b1, 16'h0CF8, 4'h3, 32'h0000_1234, 1'b1, 0, "R2");
    access(1'b0, 16'h0CF8, 4'h3, 0, 1'b1, 0, "R2");
    access(1'b0, 16'h0CF8, 4'hF, 0, 1'b0, 32'h8000_0000, "R2");
    // R10: other ports forwarded
    access(1'b1, 16'h0080, 4'h1, 32'h0000_00AB, 1'b1, 0, "R10");
    access(1'b0, 16'h03F8, 4'h1, 0, 1'b1, 0, "R10");
    // R6 / R7: command+status
    cfg_wr(32'h8000_0004, "R6");
    cfg_rd(32'h0280_0007, "R6");
    data_wr(4'h1, 32'hFFFF_FF5A, "R7");
    cfg_rd(32'h0280_005A, "R7");
    data_wr(4'hC, 32'h1234_0000, "R7");
    cfg_rd(32'h1234_005A, "R7");
    // R5: class/revision read-only
    cfg_wr(32'h8000_0008, "R5");
    cfg_rd(32'h0600_0000, "R5");
    data_wr(4'hF, 32'hFFFF_FFFF, "R5");
    cfg_rd(32'h0600_0000, "R5");
    // R8: 0Ch dword, only latency byte writable
    cfg_wr(32'h8000_000C, "R6");
    cfg_rd(32'h0000_0000, "R6");
    data_wr(4'hF, 32'hFFFF_FFFF, "R8");
    cfg_rd(32'h0000_FF00, "R8");
    // R6 / R8: control dword at 40h, 42h reserved
    cfg_wr(32'h8000_0040, "R6");
    cfg_rd(32'h8000_9600, "R6");
    data_wr(4'hF, 32'hFFFF_FFFF, "R8");
    cfg_rd(32'hFF00_FFFF, "R8");
    // R4: bits 30:24 and 1:0 ignored for selection
    cfg_wr(32'hFE00_0042, "R4");
    cfg_rd(32'hFF00_FFFF, "R4");
    // 44h
    cfg_wr(32'h8000_0044, "R6");
    cfg_rd(32'h0000_0000, "R6");
    data_wr(4'hF, 32'hFFFF_FFFF, "R8");
    cfg_rd(32'h0000_00FF, "R8");
    // R8: reserved region
    cfg_wr(32'h8000_0080, "R8");
    data_wr(4'hF, 32'hFFFF_FFFF, "R8");
    cfg_rd(32'h0000_0000, "R8");
    // R3: nonzero bus/device/function -> forwarded, write has no effect
    cfg_wr(32'h8000_0804, "R3");
    access(1'b0, 16'h0CFC, 4'hF, 0, 1'b1, 0, "R3");
    access(1'b1, 16'h0CFC, 4'hF, 32'h0, 1'b1, 0, "R3");
    cfg_wr(32'h8001_0004, "R3");
    access(1'b0, 16'h0CFC, 4'hF, 0, 1'b1, 0, "R3");
    cfg_wr(32'h8000_0004, "R3");
    cfg_rd(32'h1234_005A, "R3");
    idle();

    // R9: reset reloads defaults
    do_reset();
    access(1'b0, 16'h0CF8, 4'hF, 0, 1'b0, 32'h0, "R9");
    cfg_wr(32'h8000_0004, "R9");
    cfg_rd(32'h0280_0007, "R9");
    cfg_wr(32'h8000_0040, "R9");
    cfg_rd(32'h8000_9600, "R9");
    cfg_wr(32'h8000_000C, "R9");
    cfg_rd(32'h0000_0000, "R9");
    idle();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule